// File: doc/BRIEF.md
# Processor Watchdog Supervisor

This block watches a processor for signs of life. Software must toggle a kick input at regular intervals. Either a rising or a falling transition counts as a kick. If the kicks stop, the block reports the failure on an active-low flag output. It can also be set to force the system into reset for a fixed number of cycles. The kick input may be asynchronous to the block clock, so it is synchronized before any edge is detected.

The block has two activation modes. In the dependent mode, the timer stays inactive until the power sequencer reports completion and no other source holds the system in reset. In the free-running mode, the timer only needs the supply to be valid with boot finished. An optional long startup window can be placed in front of the routine timeout. It gives slow boot code time to reach its first kick. The first kick inside that window hands over to the routine timeout. Reaching the end of the window without a kick counts as an expiry.

On expiry, the behaviour depends on the reset-output setting. With that setting off, the flag stays low until the next kick. With it on, the block drives a timed reset pulse and gives only a short flag pulse at the start of it. When the reset pulse ends, the timer arms again from its beginning.

Top module: `wdog_supervisor`

## Requirements
- R1: With `cfg_indep` = 0, the timer does not run while `seq_done` is 0. Both outputs stay high for as long as that lasts.
- R2: With `cfg_indep` = 1, the timer runs while `seq_done` is 0. With the startup window disabled, `wdo_n` falls WD_CYC+1 cycles after activation.
- R3: While `enable` is 0 or `pwr_ok` is 0, the timer is held cleared. One cycle later both outputs are high and stay high.
- R4: With `cfg_start_en` = 1 and no kick, expiry occurs START_CYC+1 cycles after activation.
- R5: A kick inside the startup window starts the routine timeout. `wdo_n` then falls WD_CYC+3 cycles after the kick input changes.
- R6: Both a 0-to-1 and a 1-to-0 change on `kick_in` restart the routine count. A kick takes effect 3 cycles after the input changes (two synchronizer stages plus one edge register).
- R7: With `cfg_rst_out_en` = 0, `wdo_n` stays low after expiry until a kick. It returns high 3 cycles after the kick input changes.
- R8: While `sysrst_req` is 1, in either mode, the timer is held cleared. One cycle later both outputs are high.
- R9: With `cfg_rst_out_en` = 1, expiry drives `wd_rst_n` low for exactly RST_CYC cycles. `wdo_n` is low only for the first WDO_PULSE_CYC of them.
- R10: After a reset pulse, `wd_rst_n` is high for one cycle. The timer then re-arms, opening the startup window again when that window is enabled.
- R11: With `cfg_rst_out_en` = 0, an expiry never drives `wd_rst_n` low.
- R12: While `rst_n` is low, `wdo_n` and `wd_rst_n` are both high.
- R13: With the startup window disabled, the routine timeout starts at activation. `wdo_n` falls WD_CYC+1 cycles after the activating input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_indep | input | 1 | 1 = timer ignores sequencing, 0 = timer waits for sequencing |
| cfg_start_en | input | 1 | 1 = open the long startup window on each arming |
| cfg_rst_out_en | input | 1 | 1 = expiry produces a timed reset pulse |
| pwr_ok | input | 1 | Supply above undervoltage lockout and boot finished |
| seq_done | input | 1 | Power sequencing complete |
| enable | input | 1 | Watchdog enable; 0 holds the timer cleared |
| sysrst_req | input | 1 | System reset asserted by another source |
| kick_in | input | 1 | Asynchronous kick from the processor; either edge is a kick |
| wdo_n | output | 1 | Active-low watchdog flag |
| wd_rst_n | output | 1 | Active-low reset pulse requested by the watchdog |

## Verification
The bench targets the boundaries of each window. It checks the cycle just before and the cycle of every expected expiry. An off-by-one in the counters, or a wrong synchronizer latency, would move the flag edge by one cycle and be reported. A falling kick is used as well as a rising one, so a detector that sees only one edge would let the flag fall at the old deadline. The reset pulse is measured from both ends, and a second expiry after the pulse is waited for. A design that failed to re-arm, or that skipped the startup window on re-arm, would miss that second pulse or fire it early. Held-off states (sequencing incomplete, enable low, supply lost, external reset) are observed well past one full timeout. Any counting that leaks through them would show as a flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    WD_IDLE  = 3'd0,
    WD_START = 3'd1,
    WD_RUN   = 3'd2,
    WD_FLAG  = 3'd3,
    WD_PULSE = 3'd4
  } wd_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  output logic kick_edge
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = kick_async;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], kick_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign kick_edge = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wdog_gate.sv
module wdog_gate (
  input  logic cfg_indep,
  input  logic pwr_ok,
  input  logic seq_done,
  input  logic enable,
  input  logic sysrst_req,
  output logic active
);

  logic seq_ok;

  always_comb begin
    seq_ok = cfg_indep | seq_done;
    active = pwr_ok & enable & ~sysrst_req & seq_ok;
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned START_CYC     = 1000000,
  parameter int unsigned WD_CYC        = 100000,
  parameter int unsigned RST_CYC       = 20000,
  parameter int unsigned WDO_PULSE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  input  logic cfg_start_en,
  input  logic cfg_rst_out_en,
  output logic wdo_n,
  output logic wd_rst_n
);

  localparam int unsigned MAXC = max3(START_CYC, WD_CYC, RST_CYC);
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] ST_LAST = CW'(START_CYC - 1);
  localparam logic [CW-1:0] WD_LAST = CW'(WD_CYC - 1);
  localparam logic [CW-1:0] RC_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] WP_LEN  = CW'(WDO_PULSE_CYC);

  wd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  wd_state_e     expire_st;

  assign expire_st = cfg_rst_out_en ? WD_PULSE : WD_FLAG;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!active) begin
      st_d  = WD_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        WD_IDLE: begin
          st_d  = cfg_start_en ? WD_START : WD_RUN;
          cnt_d = '0;
        end
        WD_START: begin
          if (kick) begin
            st_d  = WD_RUN;
            cnt_d = '0;
          end else if (cnt_q == ST_LAST) begin
            st_d  = expire_st;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        WD_RUN: begin
          if (kick) begin
            cnt_d = '0;
          end else if (cnt_q == WD_LAST) begin
            st_d  = expire_st;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        WD_FLAG: begin
          if (kick) begin
            st_d  = WD_RUN;
            cnt_d = '0;
          end
        end
        WD_PULSE: begin
          if (cnt_q == RC_LAST) begin
            st_d  = WD_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = WD_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WD_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    wdo_n    = 1'b1;
    wd_rst_n = 1'b1;
    if (st_q == WD_FLAG) begin
      wdo_n = 1'b0;
    end
    if (st_q == WD_PULSE) begin
      wd_rst_n = 1'b0;
      wdo_n    = ~(cnt_q < WP_LEN);
    end
  end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned START_CYC     = 1000000,
  parameter int unsigned WD_CYC        = 100000,
  parameter int unsigned RST_CYC       = 20000,
  parameter int unsigned WDO_PULSE_CYC = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_indep,
  input  logic cfg_start_en,
  input  logic cfg_rst_out_en,
  input  logic pwr_ok,
  input  logic seq_done,
  input  logic enable,
  input  logic sysrst_req,
  input  logic kick_in,
  output logic wdo_n,
  output logic wd_rst_n
);

  logic kick_edge;
  logic active;

  wdog_kick_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_async(kick_in),
    .kick_edge (kick_edge)
  );

  wdog_gate u_gate (
    .cfg_indep (cfg_indep),
    .pwr_ok    (pwr_ok),
    .seq_done  (seq_done),
    .enable    (enable),
    .sysrst_req(sysrst_req),
    .active    (active)
  );

  wdog_core #(
    .START_CYC    (START_CYC),
    .WD_CYC       (WD_CYC),
    .RST_CYC      (RST_CYC),
    .WDO_PULSE_CYC(WDO_PULSE_CYC)
  ) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .kick          (kick_edge),
    .cfg_start_en  (cfg_start_en),
    .cfg_rst_out_en(cfg_rst_out_en),
    .wdo_n         (wdo_n),
    .wd_rst_n      (wd_rst_n)
  );

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int unsigned RST_CYC = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_indep,
  input logic cfg_rst_out_en,
  input logic pwr_ok,
  input logic seq_done,
  input logic enable,
  input logic sysrst_req,
  input logic wdo_n,
  input logic wd_rst_n
);

  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!wd_rst_n) begin
      low_run <= low_run + 32'd1;
    end else begin
      low_run <= '0;
    end
  end

  p_dep_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_indep && !seq_done) |=> (wdo_n && wd_rst_n));

  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !pwr_ok) |=> (wdo_n && wd_rst_n));

  p_sysrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_req |=> (wdo_n && wd_rst_n));

  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> !wdo_n);

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |-> (low_run < 32'(RST_CYC)));

  p_no_rst_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> $past(cfg_rst_out_en));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(
  .RST_CYC(RST_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_indep     (cfg_indep),
  .cfg_rst_out_en(cfg_rst_out_en),
  .pwr_ok        (pwr_ok),
  .seq_done      (seq_done),
  .enable        (enable),
  .sysrst_req    (sysrst_req),
  .wdo_n         (wdo_n),
  .wd_rst_n      (wd_rst_n)
);

// File: tb/wdog_supervisor_bench.sv
`timescale 1ns/1ps
module wdog_supervisor_bench;

  localparam int ST = 40;
  localparam int WD = 20;
  localparam int RC = 10;
  localparam int WP = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_indep, cfg_start_en, cfg_rst_out_en;
  logic pwr_ok, seq_done, enable, sysrst_req, kick_in;
  logic wdo_n, wd_rst_n;

  always #2 clk = ~clk;

  wdog_supervisor #(
    .START_CYC    (ST),
    .WD_CYC       (WD),
    .RST_CYC      (RC),
    .WDO_PULSE_CYC(WP),
    .SYNC_STAGES  (2)
  ) u_wdog_supervisor (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_indep     (cfg_indep),
    .cfg_start_en  (cfg_start_en),
    .cfg_rst_out_en(cfg_rst_out_en),
    .pwr_ok        (pwr_ok),
    .seq_done      (seq_done),
    .enable        (enable),
    .sysrst_req    (sysrst_req),
    .kick_in       (kick_in),
    .wdo_n         (wdo_n),
    .wd_rst_n      (wd_rst_n)
  );

  typedef struct {
    int    cyc;
    logic  wdo;
    logic  rst;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   wd_expired = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_now(input logic w, input logic r, input string tag);
    checks++;
    if (wdo_n !== w || wd_rst_n !== r) begin
      fails++;
      $display("FAIL %s: cycle %0d wdo_n=%b wd_rst_n=%b expected wdo_n=%b wd_rst_n=%b",
               tag, cyc, wdo_n, wd_rst_n, w, r);
    end
  endtask

  task automatic expect_at(input int k, input logic w, input logic r, input string tag);
    exp_t e;
    e.cyc = cyc + k;
    e.wdo = w;
    e.rst = r;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every queued expectation due in this cycle
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].cyc == cyc) begin
        check_now(exp_q[i].wdo, exp_q[i].rst, exp_q[i].tag);
        exp_q.delete(i);
      end
    end
  end

  task automatic run_tests();
    rst_n = 1'b0;
    cfg_indep = 1'b0; cfg_start_en = 1'b0; cfg_rst_out_en = 1'b0;
    pwr_ok = 1'b0; seq_done = 1'b0; enable = 1'b0; sysrst_req = 1'b0; kick_in = 1'b0;
    wait_cyc(3);
    check_now(1'b1, 1'b1, "R12");
    rst_n = 1'b1;
    wait_cyc(2);

    // R1: dependent mode, sequencing incomplete
    pwr_ok = 1'b1; enable = 1'b1;
    expect_at(2, 1'b1, 1'b1, "R1");
    expect_at(WD + 5, 1'b1, 1'b1, "R1");
    wait_cyc(WD + 6);

    // R13: no startup window, timeout from activation; R11 no reset pulse
    seq_done = 1'b1;
    expect_at(WD, 1'b1, 1'b1, "R13");
    expect_at(WD + 1, 1'b0, 1'b1, "R13");
    expect_at(WD + 2, 1'b0, 1'b1, "R11");
    wait_cyc(WD + 3);

    // R7: flag held, cleared by a rising kick
    expect_at(3, 1'b0, 1'b1, "R7");
    wait_cyc(4);
    kick_in = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R7");
    expect_at(3, 1'b1, 1'b1, "R7");
    wait_cyc(13);

    // R6: falling kick restarts the routine count
    kick_in = 1'b0;
    expect_at(10, 1'b1, 1'b1, "R6");
    expect_at(22, 1'b1, 1'b1, "R6");
    expect_at(23, 1'b0, 1'b1, "R6");
    wait_cyc(25);

    // R8: external reset clears flag
    sysrst_req = 1'b1;
    expect_at(1, 1'b1, 1'b1, "R8");
    wait_cyc(3);

    // R3: enable low, then supply lost
    sysrst_req = 1'b0; enable = 1'b0;
    expect_at(1, 1'b1, 1'b1, "R3");
    expect_at(WD + 5, 1'b1, 1'b1, "R3");
    wait_cyc(WD + 6);
    enable = 1'b1; pwr_ok = 1'b0;
    expect_at(WD + 5, 1'b1, 1'b1, "R3");
    wait_cyc(WD + 6);

    // R2: independent mode runs without sequencing
    cfg_indep = 1'b1; seq_done = 1'b0; pwr_ok = 1'b1;
    expect_at(WD, 1'b1, 1'b1, "R2");
    expect_at(WD + 1, 1'b0, 1'b1, "R2");
    wait_cyc(WD + 3);
    sysrst_req = 1'b1;
    expect_at(1, 1'b1, 1'b1, "R8");
    wait_cyc(2);
    enable = 1'b0; sysrst_req = 1'b0;
    cfg_indep = 1'b0; seq_done = 1'b1; cfg_start_en = 1'b1; cfg_rst_out_en = 1'b1;
    wait_cyc(2);

    // R4, R9, R10: startup expiry, reset pulse, re-arm
    enable = 1'b1;
    expect_at(ST, 1'b1, 1'b1, "R4");
    expect_at(ST + 1, 1'b0, 1'b0, "R4");
    expect_at(ST + WP, 1'b0, 1'b0, "R9");
    expect_at(ST + WP + 1, 1'b1, 1'b0, "R9");
    expect_at(ST + RC, 1'b1, 1'b0, "R9");
    expect_at(ST + RC + 1, 1'b1, 1'b1, "R9");
    expect_at(2 * ST + RC + 1, 1'b1, 1'b1, "R10");
    expect_at(2 * ST + RC + 2, 1'b0, 1'b0, "R10");
    wait_cyc(2 * ST + RC + 4);
    enable = 1'b0; cfg_rst_out_en = 1'b0;
    wait_cyc(2);

    // R5: kick inside the startup window hands over to routine timeout
    enable = 1'b1;
    wait_cyc(5);
    kick_in = 1'b1;
    expect_at(WD + 2, 1'b1, 1'b1, "R5");
    expect_at(WD + 3, 1'b0, 1'b1, "R5");
    wait_cyc(WD + 5);
    enable = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        wd_expired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_expired) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d expectations never compared, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule